// File: doc/BRIEF.md
# Status Register and Write Protection Unit

This unit keeps the status byte of a serial nonvolatile memory and decides, per request, whether a change to the storage array or to the status byte may go ahead. A serial front end hands it decoded commands: set or clear the write enable latch, load the status byte, program a page, erase a sector or erase the whole array. Each command arrives as a one-cycle strobe with an opcode, a byte address and a data byte. The write-protect pin is sampled directly.

For every command that would modify storage, the unit answers one cycle later with either an accept pulse or a reject pulse. An accepted command starts a self-timed busy interval whose length in clock cycles is a parameter for each kind of job. While that interval runs, the busy flag in the status byte is set. The array is 128 KiB, split into four 32 KiB sectors selected by the top two address bits. A two-bit protect field locks none, the top quarter, the top half or all of them. Retained bits are ordinary flip-flops whose reset values are parameters.

Top module: `sr_wp_unit`

## Requirements
- R1: After reset the status byte equals {RST_WPEN, 3'b000, RST_BP, 1'b0, 1'b0}, and neither accept_o nor reject_o is high.
- R2: The status byte holds the pin-lock enable at bit 7, the protect field at bits 3:2 and the enable latch at bit 1. The busy flag is at bit 0, and bits 6:4 always read 0. An accepted status load copies data bits 7, 3 and 2 only.
- R3: Accepted commands set the busy flag for a fixed number of cycles, starting in the cycle after the command. The count is PAGE_CYC for page programming, ERASE_CYC for sector or full erase, and SRWR_CYC for a status load.
- R4: Opcode 1 sets the enable latch and opcode 2 clears it. Both take effect in the next cycle, whatever the state of the pin, the pin-lock enable or the busy flag.
- R5: The enable latch clears in the cycle where the busy flag falls, unless an opcode 1 was given in that same cycle.
- R6: Opcode 3, 4, 5 or 6 is rejected if the enable latch is 0 or the busy flag is 1. A rejected command changes no state.
- R7: Protect field 00 locks no sector, 01 locks sector 3, 10 locks sectors 2 and 3, and 11 locks all four. The sector is given by address bits 16:15. A page program (opcode 4) or sector erase (opcode 5) aimed at a locked sector is rejected.
- R8: A full erase (opcode 6) is rejected whenever the protect field is not 00.
- R9: A status load (opcode 3) is rejected when bit 7 is 1 and wp_n is 0. It is accepted, if R6 allows, when wp_n is 1 or bit 7 is 0.
- R10: The opcodes are 0 idle, 1 latch set, 2 latch clear, 3 status load, 4 page program, 5 sector erase, 6 full erase. Opcodes 3 to 6 produce exactly one one-cycle pulse on accept_o or on reject_o, in the cycle after the command. Opcodes 0, 1 and 2 produce neither pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 3 | Command opcode (see R10) |
| cmd_addr | input | ADDR_W | Target byte address for program and erase |
| cmd_data | input | 8 | Status byte value for a status load |
| wp_n | input | 1 | Write-protect pin, active low |
| status_o | output | 8 | Current status byte |
| accept_o | output | 1 | Command accepted pulse |
| reject_o | output | 1 | Command refused pulse |

## Verification
A wrong protect field or a wrong pin-lock bit shows up first on status_o, one cycle after the status load. It then shows again as a wrong accept or reject pulse on the next program or erase aimed at the affected sector. A busy counter loaded with the wrong count moves the falling edge of bit 0, and with it the clearing of bit 1. The status byte is compared with a reference model on every clock, so such a fault is reported in the first cycle where the edge is out of place. A stuck or wrongly priorised enable latch changes bit 1 right away, and it also flips the next accept into a reject or the other way round.

// File: rtl/sr_wp_pkg.sv
package sr_wp_pkg;

    typedef enum logic [2:0] {
        OP_IDLE  = 3'd0,
        OP_WEN   = 3'd1,
        OP_WDIS  = 3'd2,
        OP_SLOAD = 3'd3,
        OP_PROG  = 3'd4,
        OP_SERS  = 3'd5,
        OP_FERS  = 3'd6,
        OP_RSV   = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        JOB_PROG  = 2'd0,
        JOB_ERASE = 2'd1,
        JOB_SREG  = 2'd2
    } job_e;

    typedef struct packed {
        logic       wpen;
        logic [2:0] rsvd;
        logic [1:0] bp;
        logic       wel;
        logic       wip;
    } status_t;

    localparam int SECT_W = 2;

    function automatic logic sector_locked(input logic [1:0] bp,
                                           input logic [SECT_W-1:0] sect);
        logic hit;
        unique case (bp)
            2'b00:   hit = 1'b0;
            2'b01:   hit = (sect == 2'd3);
            2'b10:   hit = sect[1];
            default: hit = 1'b1;
        endcase
        return hit;
    endfunction

    function automatic logic op_mutates(input op_e op);
        return (op == OP_SLOAD) || (op == OP_PROG) ||
               (op == OP_SERS)  || (op == OP_FERS);
    endfunction

endpackage

// File: rtl/sr_wp_guard.sv
module sr_wp_guard
    import sr_wp_pkg::*;
(
    input  op_e                op,
    input  logic [SECT_W-1:0]  sect,
    input  status_t            status,
    input  logic               wp_n,
    output logic               mutating,
    output logic               permit,
    output job_e               job
);
    logic base_ok;

    always_comb begin
        mutating = op_mutates(op);
        base_ok  = status.wel && !status.wip;
        permit   = 1'b0;
        job      = JOB_PROG;
        unique case (op)
            OP_SLOAD: begin
                permit = base_ok && !(status.wpen && !wp_n);
                job    = JOB_SREG;
            end
            OP_PROG: begin
                permit = base_ok && !sector_locked(status.bp, sect);
                job    = JOB_PROG;
            end
            OP_SERS: begin
                permit = base_ok && !sector_locked(status.bp, sect);
                job    = JOB_ERASE;
            end
            OP_FERS: begin
                permit = base_ok && (status.bp == 2'b00);
                job    = JOB_ERASE;
            end
            default: begin
                permit = 1'b0;
                job    = JOB_PROG;
            end
        endcase
    end
endmodule

// File: rtl/sr_wp_timer.sv
module sr_wp_timer
    import sr_wp_pkg::*;
#(
    parameter int PAGE_CYC  = 40,
    parameter int ERASE_CYC = 70,
    parameter int SRWR_CYC  = 25
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  job_e job,
    output logic busy,
    output logic done
);
    localparam int MAX_A = (PAGE_CYC > ERASE_CYC) ? PAGE_CYC : ERASE_CYC;
    localparam int MAX_C = (MAX_A > SRWR_CYC) ? MAX_A : SRWR_CYC;
    localparam int CW    = $clog2(MAX_C + 1);
    localparam logic [CW-1:0] LD_PAGE  = CW'(PAGE_CYC - 1);
    localparam logic [CW-1:0] LD_ERASE = CW'(ERASE_CYC - 1);
    localparam logic [CW-1:0] LD_SREG  = CW'(SRWR_CYC - 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] load_val;

    always_comb begin
        unique case (job)
            JOB_ERASE: load_val = LD_ERASE;
            JOB_SREG:  load_val = LD_SREG;
            default:   load_val = LD_PAGE;
        endcase
    end

    assign done = busy && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            cnt_q <= '0;
        end else if (start) begin
            busy  <= 1'b1;
            cnt_q <= load_val;
        end else if (busy) begin
            if (cnt_q == '0) begin
                busy <= 1'b0;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end
endmodule

// File: rtl/sr_wp_regs.sv
module sr_wp_regs
    import sr_wp_pkg::*;
#(
    parameter logic       RST_WPEN = 1'b0,
    parameter logic [1:0] RST_BP   = 2'b00
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       set_wel,
    input  logic       clr_wel,
    input  logic       load_sr,
    input  logic [7:0] sr_data,
    input  logic       wip,
    output status_t    status
);
    status_t    img;
    logic       wpen_q;
    logic [1:0] bp_q;
    logic       wel_q;

    assign img = status_t'(sr_data);

    always_ff @(posedge clk) begin
        if (rst) begin
            wpen_q <= RST_WPEN;
            bp_q   <= RST_BP;
            wel_q  <= 1'b0;
        end else begin
            if (load_sr) begin
                wpen_q <= img.wpen;
                bp_q   <= img.bp;
            end
            if (set_wel) begin
                wel_q <= 1'b1;
            end else if (clr_wel) begin
                wel_q <= 1'b0;
            end
        end
    end

    always_comb begin
        status      = '0;
        status.wpen = wpen_q;
        status.bp   = bp_q;
        status.wel  = wel_q;
        status.wip  = wip;
    end
endmodule

// File: rtl/sr_wp_unit.sv
module sr_wp_unit
    import sr_wp_pkg::*;
#(
    parameter int         ADDR_W    = 17,
    parameter int         PAGE_CYC  = 40,
    parameter int         ERASE_CYC = 70,
    parameter int         SRWR_CYC  = 25,
    parameter logic       RST_WPEN  = 1'b0,
    parameter logic [1:0] RST_BP    = 2'b00
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [7:0]        cmd_data,
    input  logic              wp_n,
    output logic [7:0]        status_o,
    output logic              accept_o,
    output logic              reject_o
);
    op_e               op;
    logic [SECT_W-1:0] sect;
    status_t           status;
    logic              mutating;
    logic              permit;
    job_e              job;
    logic              start;
    logic              busy;
    logic              done;
    logic              unused_bits;

    assign op          = op_e'(cmd_op);
    assign sect        = cmd_addr[ADDR_W-1 -: SECT_W];
    assign unused_bits = ^cmd_addr[ADDR_W-SECT_W-1:0];

    sr_wp_guard i_guard (
        .op       (op),
        .sect     (sect),
        .status   (status),
        .wp_n     (wp_n),
        .mutating (mutating),
        .permit   (permit),
        .job      (job)
    );

    assign start = cmd_valid && mutating && permit;

    sr_wp_timer #(
        .PAGE_CYC  (PAGE_CYC),
        .ERASE_CYC (ERASE_CYC),
        .SRWR_CYC  (SRWR_CYC)
    ) i_timer (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .job   (job),
        .busy  (busy),
        .done  (done)
    );

    sr_wp_regs #(
        .RST_WPEN (RST_WPEN),
        .RST_BP   (RST_BP)
    ) i_regs (
        .clk     (clk),
        .rst     (rst),
        .set_wel (cmd_valid && (op == OP_WEN)),
        .clr_wel ((cmd_valid && (op == OP_WDIS)) || done),
        .load_sr (start && (op == OP_SLOAD)),
        .sr_data (cmd_data),
        .wip     (busy),
        .status  (status)
    );

    assign status_o = status;

    always_ff @(posedge clk) begin
        if (rst) begin
            accept_o <= 1'b0;
            reject_o <= 1'b0;
        end else begin
            accept_o <= start;
            reject_o <= cmd_valid && mutating && !permit;
        end
    end
endmodule

// File: rtl/sr_wp_unit_chk.sv
module sr_wp_unit_chk (
    input logic       clk,
    input logic       rst,
    input logic       cmd_valid,
    input logic [2:0] cmd_op,
    input logic       wp_n,
    input logic [7:0] status_o,
    input logic       accept_o,
    input logic       reject_o
);
    assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (rst)
        status_o[6:4] == 3'b000);

    assert_busy_on_accept_R3: assert property (@(posedge clk) disable iff (rst)
        accept_o |-> status_o[0]);

    assert_wen_sets_R4: assert property (@(posedge clk) disable iff (rst)
        ($past(cmd_valid) && $past(cmd_op) == 3'd1) |-> status_o[1]);

    assert_wdis_clears_R4: assert property (@(posedge clk) disable iff (rst)
        ($past(cmd_valid) && $past(cmd_op) == 3'd2) |-> !status_o[1]);

    assert_done_clears_R5: assert property (@(posedge clk) disable iff (rst)
        ($fell(status_o[0]) && !($past(cmd_valid) && $past(cmd_op) == 3'd1))
            |-> !status_o[1]);

    assert_accept_gate_R6: assert property (@(posedge clk) disable iff (rst)
        accept_o |-> ($past(status_o[1]) && !$past(status_o[0])));

    assert_full_erase_lock_R8: assert property (@(posedge clk) disable iff (rst)
        ($past(cmd_valid) && $past(cmd_op) == 3'd6 && $past(status_o[3:2]) != 2'b00)
            |-> !accept_o);

    assert_pin_lock_R9: assert property (@(posedge clk) disable iff (rst)
        ($past(cmd_valid) && $past(cmd_op) == 3'd3 && $past(status_o[7]) && !$past(wp_n))
            |-> !accept_o);

    assert_pulse_excl_R10: assert property (@(posedge clk) disable iff (rst)
        !(accept_o && reject_o));
endmodule

bind sr_wp_unit sr_wp_unit_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .wp_n      (wp_n),
    .status_o  (status_o),
    .accept_o  (accept_o),
    .reject_o  (reject_o)
);

// File: tb/test_sr_wp_unit.sv
module test_sr_wp_unit;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 17;
    localparam int PAGE_CYC   = 40;
    localparam int ERASE_CYC  = 70;
    localparam int SRWR_CYC   = 25;
    localparam bit RST_WPEN   = 1'b0;
    localparam bit [1:0] RST_BP = 2'b00;
    localparam int WATCHDOG   = 20000;

    localparam bit [2:0] C_IDLE = 3'd0, C_WEN = 3'd1, C_WDIS = 3'd2, C_SLOAD = 3'd3,
                         C_PROG = 3'd4, C_SERS = 3'd5, C_FERS = 3'd6;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cmd_valid = 1'b0;
    logic [2:0]        cmd_op = '0;
    logic [ADDR_W-1:0] cmd_addr = '0;
    logic [7:0]        cmd_data = '0;
    logic              wp_n = 1'b1;
    logic [7:0]        status_o;
    logic              accept_o;
    logic              reject_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit started = 0;
    bit finished = 0;

    // reference model state
    bit       m_wpen;
    bit [1:0] m_bp;
    bit       m_wel;
    int       m_left;
    bit       m_acc;
    bit       m_rej;
    string    m_tag = "R10";

    always #(CLK_PERIOD/2) clk = ~clk;

    sr_wp_unit #(
        .ADDR_W(ADDR_W), .PAGE_CYC(PAGE_CYC), .ERASE_CYC(ERASE_CYC),
        .SRWR_CYC(SRWR_CYC), .RST_WPEN(RST_WPEN), .RST_BP(RST_BP)
    ) i_sr_wp_unit (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .wp_n(wp_n),
        .status_o(status_o), .accept_o(accept_o), .reject_o(reject_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    function automatic bit locked(input bit [1:0] bp, input int sect);
        case (bp)
            2'b00:   return 0;
            2'b01:   return sect == 3;
            2'b10:   return sect >= 2;
            default: return 1;
        endcase
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            m_wpen = RST_WPEN; m_bp = RST_BP; m_wel = 0; m_left = 0;
            m_acc = 0; m_rej = 0; m_tag = "R1";
        end else begin
            bit done;
            bit ok;
            bit mut;
            int sect;
            string why;
            done = (m_left == 1);
            mut  = cmd_valid && (cmd_op >= C_SLOAD) && (cmd_op <= C_FERS);
            sect = int'(cmd_addr) / 32768;
            ok   = 0;
            why  = "R10";
            if (mut) begin
                if (!m_wel || m_left > 0) begin
                    why = "R6";
                end else if (cmd_op == C_SLOAD) begin
                    ok = !(m_wpen && !wp_n); why = "R9";
                end else if (cmd_op == C_FERS) begin
                    ok = (m_bp == 2'b00); why = "R8";
                end else begin
                    ok = !locked(m_bp, sect); why = "R7";
                end
            end
            m_acc = mut && ok;
            m_rej = mut && !ok;
            m_tag = why;
            if (m_left > 0) m_left--;
            if (m_acc) begin
                m_left = (cmd_op == C_PROG) ? PAGE_CYC :
                         (cmd_op == C_SLOAD) ? SRWR_CYC : ERASE_CYC;
                if (cmd_op == C_SLOAD) begin
                    m_wpen = cmd_data[7];
                    m_bp   = cmd_data[3:2];
                end
            end
            if (cmd_valid && cmd_op == C_WEN) m_wel = 1;
            else if (cmd_valid && cmd_op == C_WDIS) m_wel = 0;
            else if (done) m_wel = 0;
            started = 1;
        end
    end

    // every-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (started && !finished) begin
            chk(status_o[0] == (m_left > 0), "R3 busy flag", status_o[0], m_left > 0);
            chk(status_o[1] == m_wel, "R4/R5 enable latch", status_o[1], m_wel);
            chk(status_o[7:2] == {m_wpen, 3'b000, m_bp}, "R2 upper bits",
                status_o[7:2], {m_wpen, 3'b000, m_bp});
            chk(accept_o == m_acc, {m_tag, " accept"}, accept_o, m_acc);
            chk(reject_o == m_rej, {m_tag, " reject"}, reject_o, m_rej);
        end
    end

    always @(posedge clk) begin
        if (cycles >= WATCHDOG && !finished) begin
            finished = 1;
            errors++;
            $display("FAIL R3 watchdog expired actual=running expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic issue(input bit [2:0] op, input int addr, input bit [7:0] data);
        @(posedge clk); #1;
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = ADDR_W'(addr); cmd_data = data;
        @(posedge clk); #1;
        cmd_valid = 1'b0; cmd_op = C_IDLE;
    endtask

    task automatic settle();
        repeat (ERASE_CYC + 4) @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk(status_o == {RST_WPEN, 3'b000, RST_BP, 2'b00}, "R1 reset status", status_o,
            {RST_WPEN, 3'b000, RST_BP, 2'b00});
        chk(!accept_o && !reject_o, "R1 no pulses in reset", {accept_o, reject_o}, 0);
        rst = 1'b0;
        repeat (2) @(posedge clk);

        issue(C_PROG, 0, 8'h00);                   // R6: latch clear
        issue(C_WEN, 0, 8'h00);
        wp_n = 1'b1;
        issue(C_SLOAD, 0, 8'h8C);                  // lock enable, all locked
        settle();
        chk(status_o == 8'h8C, "R5 latch cleared after status load", status_o, 8'h8C);

        issue(C_WEN, 0, 8'h00);
        issue(C_PROG, 0, 8'h00);                   // R7: all locked
        wp_n = 1'b0;
        issue(C_SLOAD, 0, 8'h04);                  // R9: pin lock
        issue(C_WDIS, 0, 8'h00);                   // R4
        issue(C_WEN, 0, 8'h00);                    // R4 despite pin state
        chk(status_o == 8'h8E, "R9 status unchanged by refused load", status_o, 8'h8E);
        wp_n = 1'b1;
        issue(C_SLOAD, 0, 8'h04);                  // top quarter locked
        settle();

        issue(C_WEN, 0, 8'h00);
        issue(C_PROG, 'h18000, 8'h00);             // R7: sector 3 locked
        issue(C_PROG, 'h17FFF, 8'h00);             // sector 2 allowed
        issue(C_WEN, 0, 8'h00);                    // R4 while busy
        issue(C_PROG, 'h00100, 8'h00);             // R6: busy
        settle();

        issue(C_WEN, 0, 8'h00);
        issue(C_SERS, 'h10000, 8'h00);             // allowed erase
        settle();
        issue(C_WEN, 0, 8'h00);
        issue(C_FERS, 0, 8'h00);                   // R8: field not 00
        wp_n = 1'b0;
        issue(C_SLOAD, 0, 8'h08);                  // R9: lock enable 0, accepted
        settle();
        issue(C_WEN, 0, 8'h00);
        issue(C_SERS, 'h10000, 8'h00);             // R7: half locked
        issue(C_SERS, 'h08000, 8'h00);             // sector 1 allowed
        settle();

        issue(C_WEN, 0, 8'h00);
        issue(C_SLOAD, 0, 8'h00);
        settle();
        issue(C_WEN, 0, 8'h00);
        issue(C_FERS, 0, 8'h00);                   // R8: field 00, accepted
        settle();
        wp_n = 1'b1;
        issue(C_WEN, 0, 8'h00);
        issue(C_SLOAD, 0, 8'hF3);                  // R2: only bits 7,3,2 stored
        settle();
        chk(status_o == 8'h80, "R2 masked status load", status_o, 8'h80);
        wp_n = 1'b0;
        issue(C_WEN, 0, 8'h00);
        issue(C_SLOAD, 0, 8'h00);                  // R9: refused
        repeat (3) @(posedge clk);
        #1;
        chk(status_o == 8'h82, "R9 refused load keeps byte", status_o, 8'h82);
        issue(C_IDLE, 0, 8'h00);                   // R10: no pulse
        @(negedge clk);
        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule